// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable model of a serial EEPROM that answers on a two-wire bus. It runs on a system clock that is much faster than the bus. It takes the serial clock and data lines as plain inputs and pulls the data line low through an open-drain enable. Both lines go through a synchronizer and a noise filter whose rejection window is a count of system clocks. The filtered lines are then decoded into start conditions, stop conditions and clock edges.

The array is kept in registers. The default build holds 256 bytes with an 8-byte page. Setting `ADDR_BITS` to 9 gives 512 bytes with a 16-byte page. In that build, device-address bit 1 carries word-address bit 8, and strap A0 plays no part in the match. The block supports byte and page writes, random reads, current-address reads and sequential reads.

Write data is collected in a page buffer. It reaches the array only when a stop condition closes the frame, and it is then held off by a write-protect input. After each commit, an internal write cycle of `WR_CYC` clocks follows, during which the block refuses to acknowledge. A master can poll the device address to find out when the cycle has finished.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset the block releases SDA and every array byte reads 0x00.
- R2: A device byte is accepted only when bits [7:4] are 1010, bits [3:2] equal straps A2,A1 and, in the 256-byte build, bit 1 equals strap A0. Bit 0 is R/W, with 0 meaning write. An accepted byte is acknowledged by pulling SDA low in the ninth clock. Any other device byte is not acknowledged, and the rest of its frame has no effect.
- R3: In a write frame, each data byte after the word address is acknowledged and buffered. The buffered bytes appear in the array only after a stop condition.
- R4: Within a write frame, the word address advances inside its page only: 8-byte pages in the 256-byte build and 16-byte pages in the 512-byte build. The page bits stay fixed. A byte written past the page end overwrites the earliest slot of that page.
- R5: A write frame closed by a repeated start instead of a stop changes no array byte and starts no write cycle.
- R6: For `WR_CYC` clocks after a commit, device bytes are not acknowledged. After that, they are acknowledged again.
- R7: While write-protect is high, a write frame (still acknowledged) leaves the array unchanged and starts no write cycle, and reads work normally.
- R8: A random read returns bytes MSB first from the given word address. It keeps returning successive addresses while the master acknowledges, and it wraps from the last array address to 0. A master NACK followed by stop leaves SDA released.
- R9: A read header with no word address first returns the byte that follows the last byte read.
- R10: In the 512-byte build, device-address bit 1 is word-address bit 8, and strap A0 is ignored.
- R11: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks has no effect on a transfer.
- R12: The block starts pulling SDA low only while the filtered SCL is low, and the data it drives stays stable through each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_a | input | 3 | Address straps {A2,A1,A0} |
| wp_i | input | 1 | Write protect, 1 inhibits array writes |

## Verification
The bench covers several write-frame cases:
- A page write that starts near a page end. A design that runs the address across the page border would corrupt the neighbouring page.
- A frame longer than a page, which must overwrite its earliest slots.
- A write frame abandoned by a repeated start, which a careless design would still commit.

The bench polls the device address straight after a commit to confirm the busy refusal. It does the same under write-protect, to confirm that no busy period follows. Reads cover the wrap from the last address to 0 and a current-address read after a random read; an off-by-one pointer shows up in both. The 512-byte instance is driven through its block bit to catch a design that still matches A0. Sub-window glitches are injected on both lines inside a data bit; an unfiltered design would shift an extra bit or see a false start.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WORD,
      ST_WORD_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_READ,
      ST_MACK
   } eep_state_e;

   localparam logic [3:0] DEV_TYPE = 4'b1010;

   function automatic int page_bytes(input int addr_bits);
      return (addr_bits > 8) ? 16 : 8;
   endfunction

endpackage

// File: rtl/eep_deglitch.sv
module eep_deglitch #(
   parameter int FILT_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

   generate
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("eep_deglitch: FILT_CYC must be at least 1");
      end
   endgenerate

   logic [1:0]    sync_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 2'b11;
         cnt_q  <= '0;
         dout   <= 1'b1;
      end else begin
         sync_q <= {sync_q[0], din};
         if (sync_q[1] == dout) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(FILT_CYC - 1)) begin
            dout  <= sync_q[1];
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
   parameter int WR_CYC = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic busy
);
   localparam int CW = (WR_CYC < 2) ? 1 : $clog2(WR_CYC + 1);

   generate
      if (WR_CYC < 1) begin : g_bad_wr
         $error("eep_wr_timer: WR_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (kick) begin
         cnt_q <= CW'(WR_CYC);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
   import eep_pkg::*;
#(
   parameter int ADDR_BITS = 8,
   parameter int FILT_CYC  = 10,
   parameter int WR_CYC    = 1_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] strap_a,
   input  logic       wp_i
);
   localparam int DEPTH = 1 << ADDR_BITS;
   localparam int PAGE  = page_bytes(ADDR_BITS);
   localparam int OFFW  = $clog2(PAGE);

   generate
      if (ADDR_BITS != 8 && ADDR_BITS != 9) begin : g_bad_aw
         $error("eep_i2c_slave: ADDR_BITS must be 8 or 9");
      end
   endgenerate

   // line conditioning
   logic [1:0] raw_lines, flt_lines;
   logic       scl_f, sda_f;
   logic       scl_rise, scl_fall, start_det, stop_det;
   logic       busy, commit;

   assign raw_lines = {scl_i, sda_i};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_flt
         eep_deglitch #(.FILT_CYC(FILT_CYC)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (flt_lines[g])
         );
      end
   endgenerate

   assign scl_f = flt_lines[1];
   assign sda_f = flt_lines[0];

   eep_bus_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl      (scl_f),
      .sda      (sda_f),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   eep_wr_timer #(.WR_CYC(WR_CYC)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .kick (commit),
      .busy (busy)
   );

   // protocol state
   eep_state_e           state;
   logic [7:0]           shreg, obuf, rd_byte;
   logic [2:0]           bitcnt;
   logic                 byte_rdy, rw_q;
   logic [ADDR_BITS-1:0] ptr, ptr_hdr;
   logic                 lo_match, hdr_ok, receiving;
   logic [7:0]           mem  [DEPTH];
   logic [7:0]           wbuf [PAGE];
   logic [PAGE-1:0]      bvalid;

   // header bit 1: strap compare or block bit, chosen by array size
   generate
      if (ADDR_BITS == 9) begin : g_blk_bit
         assign ptr_hdr  = {shreg[1], ptr[7:0]};
         assign lo_match = strap_a[0] | ~strap_a[0];
      end else begin : g_strap_bit
         assign ptr_hdr  = ptr;
         assign lo_match = (shreg[1] == strap_a[0]);
      end
   endgenerate

   assign hdr_ok    = (shreg[7:4] == DEV_TYPE) && (shreg[3:2] == strap_a[2:1])
                      && lo_match && !busy;
   assign rd_byte   = mem[ptr];
   assign receiving = (state == ST_DEV) || (state == ST_WORD) || (state == ST_DATA);
   assign commit    = stop_det && ((state == ST_DATA) || (state == ST_DATA_ACK))
                      && (|bvalid) && !wp_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         obuf     <= '0;
         bitcnt   <= '0;
         byte_rdy <= 1'b0;
         rw_q     <= 1'b0;
         ptr      <= '0;
         bvalid   <= '0;
         sda_oe_o <= 1'b0;
         for (int s = 0; s < PAGE; s++) wbuf[s] <= '0;
      end else if (start_det) begin
         state    <= ST_DEV;
         bitcnt   <= '0;
         byte_rdy <= 1'b0;
         bvalid   <= '0;
         sda_oe_o <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         byte_rdy <= 1'b0;
         bvalid   <= '0;
         sda_oe_o <= 1'b0;
      end else begin
         if (receiving && scl_rise) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 3'd7) byte_rdy <= 1'b1;
         end
         unique case (state)
            ST_DEV: begin
               if (scl_fall && byte_rdy) begin
                  byte_rdy <= 1'b0;
                  if (hdr_ok) begin
                     sda_oe_o <= 1'b1;
                     rw_q     <= shreg[0];
                     ptr      <= ptr_hdr;
                     state    <= ST_DEV_ACK;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_DEV_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (rw_q) begin
                     obuf     <= rd_byte;
                     sda_oe_o <= ~rd_byte[7];
                     ptr      <= ptr + 1'b1;
                     state    <= ST_READ;
                  end else begin
                     sda_oe_o <= 1'b0;
                     state    <= ST_WORD;
                  end
               end
            end
            ST_WORD: begin
               if (scl_fall && byte_rdy) begin
                  byte_rdy <= 1'b0;
                  ptr[7:0] <= shreg;
                  sda_oe_o <= 1'b1;
                  state    <= ST_WORD_ACK;
               end
            end
            ST_WORD_ACK, ST_DATA_ACK: begin
               if (scl_fall) begin
                  sda_oe_o <= 1'b0;
                  bitcnt   <= '0;
                  state    <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (scl_fall && byte_rdy) begin
                  byte_rdy                <= 1'b0;
                  wbuf[ptr[OFFW-1:0]]     <= shreg;
                  bvalid[ptr[OFFW-1:0]]   <= 1'b1;
                  ptr[OFFW-1:0]           <= ptr[OFFW-1:0] + 1'b1;
                  sda_oe_o                <= 1'b1;
                  state                   <= ST_DATA_ACK;
               end
            end
            ST_READ: begin
               if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     sda_oe_o <= 1'b0;
                     state    <= ST_MACK;
                  end else begin
                     obuf     <= {obuf[6:0], 1'b0};
                     sda_oe_o <= ~obuf[6];
                     bitcnt   <= bitcnt + 1'b1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  if (sda_f) state <= ST_IDLE;
                  else       byte_rdy <= 1'b1;
               end else if (scl_fall && byte_rdy) begin
                  byte_rdy <= 1'b0;
                  bitcnt   <= '0;
                  obuf     <= rd_byte;
                  sda_oe_o <= ~rd_byte[7];
                  ptr      <= ptr + 1'b1;
                  state    <= ST_READ;
               end
            end
            default: ;
         endcase
      end
   end

   // array: whole buffered page lands in one clock at stop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      end else if (commit) begin
         for (int s = 0; s < PAGE; s++) begin
            if (bvalid[s]) mem[{ptr[ADDR_BITS-1:OFFW], OFFW'(s)}] <= wbuf[s];
         end
      end
   end
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk
   import eep_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_f,
   input logic       sda_oe,
   input logic       start_det,
   input logic       stop_det,
   input logic       busy,
   input logic       wp,
   input eep_state_e state
);
   // R12
   oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_f);

   // R12
   oe_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> (!scl_f || $past(start_det) || $past(stop_det)));

   // R6
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV_ACK) |-> !busy);

   // R5
   busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det));

   // R7
   busy_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(wp));

   // R8
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(stop_det) |-> !sda_oe);

   // R8
   mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MACK) |-> !sda_oe);
endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_f    (scl_f),
   .sda_oe   (sda_oe_o),
   .start_det(start_det),
   .stop_det (stop_det),
   .busy     (busy),
   .wp       (wp_i),
   .state    (state)
);

// File: tb/tb_eep_i2c_slave.sv
module tb_eep_i2c_slave;
   localparam int Q     = 20;
   localparam int WRC   = 1000;
   localparam int FILT  = 10;
   localparam logic [6:0] DEV_A = 7'h55;  // 1010 101

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m_low = 1'b0;
   logic wp = 1'b0;
   logic oe_a, oe_b;
   logic sda_bus;

   always #5 clk = ~clk;

   assign sda_bus = ~(sda_m_low | oe_a | oe_b);

   eep_i2c_slave #(.ADDR_BITS(8), .FILT_CYC(FILT), .WR_CYC(WRC)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(oe_a), .strap_a(3'b101), .wp_i(wp));

   eep_i2c_slave #(.ADDR_BITS(9), .FILT_CYC(FILT), .WR_CYC(WRC)) dut_b (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(oe_b), .strap_a(3'b001), .wp_i(wp));

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   bit stable_err = 1'b0;
   logic [7:0] ref_a [256];
   logic [7:0] ref_b [512];
   logic [7:0] wdat  [16];

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_m_low = 1'b0; tick(Q);
      scl_m = 1'b1;     tick(2*Q);
      sda_m_low = 1'b1; tick(2*Q);
      scl_m = 1'b0;     tick(Q);
   endtask

   task automatic bus_stop();
      sda_m_low = 1'b1; tick(Q);
      scl_m = 1'b1;     tick(2*Q);
      sda_m_low = 1'b0; tick(2*Q);
   endtask

   task automatic wbit(input logic b);
      sda_m_low = ~b; tick(Q);
      scl_m = 1'b1;   tick(2*Q);
      scl_m = 1'b0;   tick(Q);
   endtask

   task automatic rbit(output logic b);
      logic late;
      sda_m_low = 1'b0; tick(Q);
      scl_m = 1'b1;     tick(Q);
      b = sda_bus;      tick(Q - 2);
      late = sda_bus;   tick(2);
      if (late !== b) stable_err = 1'b1;
      scl_m = 1'b0;     tick(Q);
   endtask

   task automatic wbyte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      rbit(b);
      ack = ~b;
   endtask

   // bit 7 carries a short SCL dip and a short SDA dip inside its high phase
   task automatic wbyte_glitch(input logic [7:0] v, output logic ack);
      logic b;
      sda_m_low = ~v[7]; tick(Q);
      scl_m = 1'b1;      tick(8);
      scl_m = 1'b0;      tick(3);
      scl_m = 1'b1;      tick(8);
      sda_m_low = 1'b1;  tick(3);
      sda_m_low = ~v[7]; tick(2*Q - 22);
      scl_m = 1'b0;      tick(Q);
      for (int i = 6; i >= 0; i--) wbit(v[i]);
      rbit(b);
      ack = ~b;
   endtask

   task automatic rbyte(output logic [7:0] v, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         v[i] = b;
      end
      wbit(~give_ack);
   endtask

   function automatic int full_addr(input bit bsel, input logic [6:0] dev,
                                    input logic [7:0] word);
      return bsel ? {23'd0, dev[0], word} : {24'd0, word};
   endfunction

   task automatic model_store(input bit bsel, input int full, input int n);
      int pg, base, off;
      pg   = bsel ? 16 : 8;
      base = full - (full % pg);
      off  = full % pg;
      for (int i = 0; i < n; i++) begin
         if (bsel) ref_b[base + ((off + i) % pg)] = wdat[i];
         else      ref_a[base + ((off + i) % pg)] = wdat[i];
      end
   endtask

   task automatic page_write(input bit bsel, input logic [6:0] dev,
                             input logic [7:0] word, input int n,
                             input bit expect_commit, input string req);
      logic ack;
      bus_start();
      wbyte({dev, 1'b0}, ack); chk(req, ack, 1);
      wbyte(word, ack);        chk(req, ack, 1);
      for (int i = 0; i < n; i++) begin
         wbyte(wdat[i], ack);
         chk(req, ack, 1);
      end
      bus_stop();
      if (expect_commit) model_store(bsel, full_addr(bsel, dev, word), n);
   endtask

   task automatic rand_read(input bit bsel, input logic [6:0] dev,
                            input logic [7:0] word, input int n,
                            input string req);
      logic ack;
      logic [7:0] v;
      int full, size, exp;
      full = full_addr(bsel, dev, word);
      size = bsel ? 512 : 256;
      bus_start();
      wbyte({dev, 1'b0}, ack); chk(req, ack, 1);
      wbyte(word, ack);        chk(req, ack, 1);
      bus_start();
      wbyte({dev, 1'b1}, ack); chk(req, ack, 1);
      for (int i = 0; i < n; i++) begin
         rbyte(v, i != n - 1);
         exp = bsel ? int'(ref_b[(full + i) % size]) : int'(ref_a[(full + i) % size]);
         chk(req, v, exp);
      end
      bus_stop();
      chk("R8 release", sda_bus, 1);
   endtask

   task automatic fill(input int n, input int seed);
      for (int i = 0; i < n; i++) wdat[i] = 8'((i * 37 + seed) & 8'hFF);
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic ack;
      logic [7:0] v;
      for (int i = 0; i < 256; i++) ref_a[i] = 8'h00;
      for (int i = 0; i < 512; i++) ref_b[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(20);

      // R1: released bus and zeroed array
      chk("R1 sda", sda_bus, 1);
      chk("R1 oe", oe_a | oe_b, 0);
      rand_read(1'b0, DEV_A, 8'h00, 2, "R1");

      // R3: page write of 8 bytes at a page start
      fill(8, 5);
      page_write(1'b0, DEV_A, 8'h10, 8, 1'b1, "R3");
      // R6: poll during the write cycle
      bus_start(); wbyte({DEV_A, 1'b0}, ack); chk("R6 busy", ack, 0); bus_stop();
      tick(WRC + 200);
      bus_start(); wbyte({DEV_A, 1'b0}, ack); chk("R6 done", ack, 1); bus_stop();
      rand_read(1'b0, DEV_A, 8'h10, 10, "R3");

      // R4: wrap inside the page from near its end
      fill(4, 101);
      page_write(1'b0, DEV_A, 8'h1E, 4, 1'b1, "R4");
      tick(WRC + 200);
      rand_read(1'b0, DEV_A, 8'h18, 8, "R4 wrap");

      // R4: more bytes than the page holds
      fill(10, 200);
      page_write(1'b0, DEV_A, 8'h20, 10, 1'b1, "R4");
      tick(WRC + 200);
      rand_read(1'b0, DEV_A, 8'h20, 8, "R4 overflow");

      // R5: write frame cut by a repeated start commits nothing
      bus_start();
      wbyte({DEV_A, 1'b0}, ack); chk("R5", ack, 1);
      wbyte(8'h30, ack);         chk("R5", ack, 1);
      wbyte(8'h99, ack);         chk("R5", ack, 1);
      bus_start();
      wbyte({DEV_A, 1'b0}, ack); chk("R5 no busy", ack, 1);
      wbyte(8'h30, ack);         chk("R5", ack, 1);
      bus_start();
      wbyte({DEV_A, 1'b1}, ack); chk("R5", ack, 1);
      rbyte(v, 1'b0);            chk("R5 unchanged", v, 8'h00);
      bus_stop();

      // R7: write protect
      wp = 1'b1;
      fill(1, 8'h77);
      page_write(1'b0, DEV_A, 8'h40, 1, 1'b0, "R7 ack");
      bus_start(); wbyte({DEV_A, 1'b0}, ack); chk("R7 no busy", ack, 1); bus_stop();
      rand_read(1'b0, DEV_A, 8'h40, 1, "R7 unchanged");
      wp = 1'b0;

      // R2: wrong A0 and wrong type code are refused
      bus_start(); wbyte({7'h54, 1'b0}, ack); chk("R2 strap", ack, 0); bus_stop();
      bus_start(); wbyte({7'h5D, 1'b1}, ack); chk("R2 type", ack, 0);  bus_stop();
      chk("R2 release", sda_bus, 1);

      // R9: current-address read follows the last byte read
      rand_read(1'b0, DEV_A, 8'h12, 1, "R9 setup");
      bus_start(); wbyte({DEV_A, 1'b1}, ack); chk("R9", ack, 1);
      rbyte(v, 1'b0); chk("R9 next", v, ref_a[8'h13]);
      bus_stop();

      // R8: sequential read wraps from 0xFF to 0x00
      fill(8, 3);
      page_write(1'b0, DEV_A, 8'hF8, 8, 1'b1, "R8 setup");
      tick(WRC + 200);
      rand_read(1'b0, DEV_A, 8'hFE, 3, "R8 wrap");

      // R11: short pulses on SCL and SDA inside a data bit
      bus_start();
      wbyte({DEV_A, 1'b0}, ack); chk("R11", ack, 1);
      wbyte(8'h60, ack);         chk("R11", ack, 1);
      wbyte_glitch(8'hC3, ack);  chk("R11 ack", ack, 1);
      bus_stop();
      ref_a[8'h60] = 8'hC3;
      tick(WRC + 200);
      rand_read(1'b0, DEV_A, 8'h60, 1, "R11 data");

      // R10: 512-byte build, block bit in header, 16-byte page wrap
      fill(12, 17);
      page_write(1'b1, 7'h51, 8'h08, 12, 1'b1, "R10");
      tick(WRC + 200);
      rand_read(1'b1, 7'h51, 8'h00, 16, "R10 high block");
      rand_read(1'b1, 7'h50, 8'h08, 1, "R10 low block");

      // R12: driven data stable through each SCL high phase
      chk("R12 stable", stable_err, 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule